// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral with a small 16-bit register interface. A programmable initial value feeds a 10-bit down-counter. The counter steps down by one on every cycle where the tick-enable input is high and the counter is not halted. A separate divider outside the block supplies the tick; one tick is meant to stand for 0.6 s, so a timeout of S seconds is programmed as S*10/6 ticks. Software keeps the system alive by writing a fixed key to the reload register, which puts the programmed initial value back into the counter. Reading the same register returns the live count.

When the counter runs out, the block records a first timeout and reloads itself. If it runs out a second time before software clears that first timeout, the block sets a second-timeout flag and a boot flag. It also pulses a one-clock system reset request. A no-reboot control bit can suppress that pulse while the status flags still record the event. An interrupt output reports the first timeout when its enable bit is set. Status flags are cleared by writing 1 to them.

Top module: `wdt_two_stage`

## Requirements
- R1: While running, the count drops by one on each cycle with `tick_i` high. A tick that arrives while the count is 0 is an expiry, and the count reloads from the initial value. After a reload to N, the expiry therefore comes on tick N+1.
- R2: The initial-value register (address 4) holds the initial value in bits 9:0. Bits 15:10 are plain storage and are written on every write to the register. A read returns both fields as they are stored.
- R3: A write to address 4 whose bits 9:0 are below 4 leaves the stored initial value unchanged. The stored value is never below 4.
- R4: Writing exactly 0x0001 to address 0 loads the initial value into the counter; any other data written there has no effect. A reload wins over a tick in the same cycle. A read of address 0 returns the count in bits 9:0.
- R5: Bit 11 of the control register (address 3) is a halt bit. When it is 1 the count is frozen; when it is 0 the count runs. The bit reads back as written.
- R6: The first expiry sets bit 3 of status register 1 (address 1).
- R7: An expiry while status 1 bit 3 is already set sets bit 1 (second timeout) and bit 2 (boot) of status register 2 (address 2). In the next cycle `rst_req_o` is high for exactly one clock.
- R8: Status bits are write-1-to-clear; writing 0 to a bit leaves it as it is. After status 1 bit 3 has been cleared, the next expiry counts as a first timeout again.
- R9: Bit 0 of the control register is a no-reboot bit. While it is 1, `rst_req_o` stays low, and status 2 still records the second timeout. The bit reads back as written.
- R10: `irq_o` is high while status 1 bit 3 is set and bit 13 of the interrupt-enable register (address 5) is 1. When that enable bit is 0, `irq_o` stays low.
- R11: After reset the registers read as follows: control 0x0801 (halted, no-reboot set), initial value 0x0004, count 0x0004, both status registers 0. `irq_o` and `rst_req_o` are low.
- R12: Read data is registered: `rdata_o` shows the addressed register in the cycle after `rd_en_i`. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Counting tick enable from an external divider |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | First-timeout interrupt |
| rst_req_o | output | 1 | One-clock system reset request |

## Verification
The bench builds the block with its default parameters: a 10-bit counter, a minimum legal initial value of 4, and a reset initial value of 4. It holds `tick_i` high for whole stretches of cycles, so with an initial value of 8 each expiry arrives within nine cycles. That keeps both timeout stages, the restart after a clear, and the no-reboot masking within a short run. A vector table writes the initial-value register with values at the lower legal edge, with values just below it, at the 10-bit maximum, and with the upper storage bits set, then reads each one back.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_COUNT = 3'd0,
    A_STS1  = 3'd1,
    A_STS2  = 3'd2,
    A_CTRL  = 3'd3,
    A_INIT  = 3'd4,
    A_IRQEN = 3'd5
  } wdt_addr_e;

  localparam int HALT_BIT     = 11;
  localparam int NOREBOOT_BIT = 0;
  localparam int FIRST_BIT    = 3;
  localparam int SECOND_BIT   = 1;
  localparam int BOOT_BIT     = 2;
  localparam int IRQEN_BIT    = 13;

  localparam logic [DATA_W-1:0] RELOAD_KEY = 16'h0001;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MIN_INIT = 4,
  parameter int INIT_RST = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              halt,
  output logic              noreboot,
  output logic              irq_en,
  output logic [CNT_W-1:0]  init_val,
  output logic [DATA_W-CNT_W-1:0] init_hi,
  output logic              reload
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_INIT);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(INIT_RST);

  logic init_ok;

  assign init_ok = (wdata[CNT_W-1:0] >= MIN_V);
  assign reload  = wr_en && (addr == A_COUNT) && (wdata == RELOAD_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      halt     <= 1'b1;
      noreboot <= 1'b1;
      irq_en   <= 1'b0;
      init_val <= RST_V;
      init_hi  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          halt     <= wdata[HALT_BIT];
          noreboot <= wdata[NOREBOOT_BIT];
        end
        A_INIT: begin
          init_hi <= wdata[DATA_W-1:CNT_W];
          if (init_ok) init_val <= wdata[CNT_W-1:0];
        end
        A_IRQEN: irq_en <= wdata[IRQEN_BIT];
        default: ;
      endcase
    end
  end

  // R3: the stored initial value never drops below the legal floor
  p_init_floor_r3: assert property (@(posedge clk) disable iff (rst)
    init_val >= MIN_V);

  // R3: a write with an illegal low field leaves the value alone
  p_reject_low_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_INIT && wdata[CNT_W-1:0] < MIN_V) |=> $stable(init_val));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             halt,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(INIT_RST);

  logic run;

  assign run    = tick && !halt;
  assign expire = run && !reload && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)             cnt <= RST_V;
    else if (reload)     cnt <= init_val;
    else if (run) begin
      if (cnt == '0)     cnt <= init_val;
      else               cnt <= cnt - 1'b1;
    end
  end

  // R5: a halted counter without reload keeps its value
  p_halt_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (halt && !reload) |=> $stable(cnt));

  // R4: a reload lands the programmed value
  p_reload_load_r4: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cnt == $past(init_val)));

  // R1: a running tick on a nonzero count steps down by one
  p_step_down_r1: assert property (@(posedge clk) disable iff (rst)
    (run && !reload && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              expire,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              noreboot,
  input  logic              irq_en,
  output logic              first_to,
  output logic              second_to,
  output logic              boot_sts,
  output logic              irq,
  output logic              rst_req
);
  logic clr_first, clr_second, clr_boot, stage2;

  assign clr_first  = wr_en && (addr == A_STS1) && wdata[FIRST_BIT];
  assign clr_second = wr_en && (addr == A_STS2) && wdata[SECOND_BIT];
  assign clr_boot   = wr_en && (addr == A_STS2) && wdata[BOOT_BIT];
  assign stage2     = expire && first_to;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_to  <= 1'b0;
      second_to <= 1'b0;
      boot_sts  <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      if (expire)          first_to  <= 1'b1;
      else if (clr_first)  first_to  <= 1'b0;
      if (stage2)          second_to <= 1'b1;
      else if (clr_second) second_to <= 1'b0;
      if (stage2)          boot_sts  <= 1'b1;
      else if (clr_boot)   boot_sts  <= 1'b0;
      rst_req <= stage2 && !noreboot;
    end
  end

  assign irq = first_to && irq_en;

  // R7: the reset request never lasts longer than one clock
  p_req_one_clock_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R7: the second-timeout flag only rises after a first timeout
  p_second_after_first_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(second_to) |-> $past(first_to));

  // R9: no reset request follows a cycle with no-reboot set
  p_noreboot_mask_r9: assert property (@(posedge clk) disable iff (rst)
    noreboot |=> !rst_req);

  // R9: every request is recorded in status 2
  p_req_recorded_r9: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> second_to);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MIN_INIT = 4,
  parameter int INIT_RST = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [2:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        irq_o,
  output logic        rst_req_o
);
  logic                    halt, noreboot, irq_en, reload, expire;
  logic [CNT_W-1:0]        init_val, cnt;
  logic [DATA_W-CNT_W-1:0] init_hi;
  logic                    first_to, second_to, boot_sts;
  logic [DATA_W-1:0]       rd_word, rdata_q;

  wdt_regs #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT), .INIT_RST(INIT_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
    .halt(halt), .noreboot(noreboot), .irq_en(irq_en),
    .init_val(init_val), .init_hi(init_hi), .reload(reload)
  );

  wdt_counter #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_i), .halt(halt), .reload(reload),
    .init_val(init_val), .cnt(cnt), .expire(expire)
  );

  wdt_status u_sts (
    .clk(clk), .rst(rst), .expire(expire), .wr_en(wr_en_i), .addr(addr_i),
    .wdata(wdata_i), .noreboot(noreboot), .irq_en(irq_en),
    .first_to(first_to), .second_to(second_to), .boot_sts(boot_sts),
    .irq(irq_o), .rst_req(rst_req_o)
  );

  always_comb begin
    rd_word = '0;
    case (addr_i)
      A_COUNT: rd_word[CNT_W-1:0] = cnt;
      A_STS1:  rd_word[FIRST_BIT] = first_to;
      A_STS2: begin
        rd_word[SECOND_BIT] = second_to;
        rd_word[BOOT_BIT]   = boot_sts;
      end
      A_CTRL: begin
        rd_word[HALT_BIT]     = halt;
        rd_word[NOREBOOT_BIT] = noreboot;
      end
      A_INIT:  rd_word = {init_hi, init_val};
      A_IRQEN: rd_word[IRQEN_BIT] = irq_en;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_word;
  end

  assign rdata_o = rdata_q;

  // R12: unmapped addresses return zero one cycle later
  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i > 3'd5) |=> (rdata_o == '0));
endmodule

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o, rst_req_o;

  int checks = 0, fails = 0, req_count = 0, long_pulse = 0;
  bit prev_req = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  wdt_two_stage u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rst_req_o) req_count++;
      if (rst_req_o && prev_req) long_pulse++;
      prev_req = rst_req_o;
    end
  end

  // {write data, expected readback} for the initial-value register
  localparam logic [31:0] VEC [8] = '{
    {16'h0010, 16'h0010}, {16'h0003, 16'h0010}, {16'hFC00, 16'hFC10},
    {16'h03FF, 16'h03FF}, {16'h8005, 16'h8005}, {16'h0004, 16'h0004},
    {16'h7C02, 16'h7C04}, {16'h0200, 16'h0200}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk);
    d = rdata_o;
    rd_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    rd(3'd3, d); check("R11 ctrl", d, 16'h0801);
    rd(3'd4, d); check("R11 init", d, 16'h0004);
    rd(3'd0, d); check("R11 count", d, 16'h0004);
    rd(3'd1, d); check("R11 sts1", d, 16'h0000);
    rd(3'd2, d); check("R11 sts2", d, 16'h0000);
    check("R11 irq", {15'd0, irq_o}, 16'h0000);
    check("R11 rst_req", {15'd0, rst_req_o}, 16'h0000);
    rd(3'd6, d); check("R12 unmapped", d, 16'h0000);

    // R2 R3 vector table on the initial-value register
    for (int i = 0; i < 8; i++) begin
      wr(3'd4, VEC[i][31:16]);
      rd(3'd4, d);
      check("R2/R3 init vector", d, VEC[i][15:0]);
    end

    // R5 halted: ticks do nothing
    ticks(10);
    rd(3'd0, d); check("R5 halted count", d, 16'h0004);

    // R1 R4 run and count
    wr(3'd3, 16'h0000);
    rd(3'd3, d); check("R5 ctrl readback", d, 16'h0000);
    wr(3'd4, 16'h0008);
    wr(3'd0, 16'h0001);
    rd(3'd0, d); check("R4 reload", d, 16'h0008);
    ticks(3);
    rd(3'd0, d); check("R1 three ticks", d, 16'h0005);

    // R4 reload beats a same-cycle tick
    tick_i = 1'b1;
    wr(3'd0, 16'h0001);
    tick_i = 1'b0;
    rd(3'd0, d); check("R4 reload over tick", d, 16'h0008);
    ticks(2);
    wr(3'd0, 16'h0002);
    rd(3'd0, d); check("R4 non-key ignored", d, 16'h0006);

    // R1 R6 first expiry on tick N+1
    wr(3'd0, 16'h0001);
    ticks(8);
    rd(3'd0, d); check("R1 count at zero", d, 16'h0000);
    rd(3'd1, d); check("R1 no expiry yet", d, 16'h0000);
    ticks(1);
    rd(3'd1, d); check("R6 first timeout", d, 16'h0008);
    rd(3'd0, d); check("R1 reloaded after expiry", d, 16'h0008);

    // R10 interrupt gating
    check("R10 irq disabled", {15'd0, irq_o}, 16'h0000);
    wr(3'd5, 16'h2000);
    check("R10 irq enabled", {15'd0, irq_o}, 16'h0001);
    wr(3'd5, 16'h0000);
    check("R10 irq off again", {15'd0, irq_o}, 16'h0000);

    // R7 second expiry
    ticks(9);
    repeat (2) @(negedge clk);
    rd(3'd2, d); check("R7 second+boot", d, 16'h0006);
    check("R7 one request", 16'(req_count), 16'd1);
    check("R7 pulse width", 16'(long_pulse), 16'd0);

    // R8 write-1-to-clear
    wr(3'd2, 16'h0000);
    rd(3'd2, d); check("R8 zero write keeps", d, 16'h0006);
    wr(3'd2, 16'h0002);
    rd(3'd2, d); check("R8 clear second", d, 16'h0004);
    wr(3'd2, 16'h0004);
    rd(3'd2, d); check("R8 clear boot", d, 16'h0000);
    wr(3'd1, 16'h0008);
    rd(3'd1, d); check("R8 clear first", d, 16'h0000);

    // R8 sequence restarts: next expiry is a first timeout again
    wr(3'd0, 16'h0001);
    ticks(9);
    repeat (2) @(negedge clk);
    rd(3'd1, d); check("R8 restart first", d, 16'h0008);
    rd(3'd2, d); check("R8 restart no second", d, 16'h0000);
    check("R8 no new request", 16'(req_count), 16'd1);

    // R9 no-reboot masks the request but status records it
    wr(3'd3, 16'h0001);
    rd(3'd3, d); check("R9 ctrl readback", d, 16'h0001);
    ticks(9);
    repeat (2) @(negedge clk);
    rd(3'd2, d); check("R9 status recorded", d, 16'h0006);
    check("R9 request masked", 16'(req_count), 16'd1);

    // R5 halt while running freezes
    wr(3'd3, 16'h0800);
    rd(3'd0, d);
    ticks(5);
    begin
      logic [15:0] d2;
      rd(3'd0, d2); check("R5 frozen when halted", d2, d);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule